// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores received frames into a ring of receive descriptors that sits in external byte-addressed memory next to the host's other data structures. When the first byte of a frame arrives, the engine reads descriptor status bytes. It starts at its receive pointer and wraps modulo the ring size until it finds an entry that the host has handed over. It then writes the frame bytes into that entry's fixed-size buffer. After the last byte it writes the byte count and then the completion status, and it raises a one-cycle receive interrupt request.

A frame that arrives while the stop input is high is consumed and discarded without any memory access. A frame that finds no free descriptor in a full pass of the ring is also consumed and discarded, and the engine raises a one-cycle missed-frame pulse. Memory is reached through a single-beat byte request port: the request stays up until it is acknowledged. The memory region starts at a 32-bit base address. It holds a 24-byte header, then the receive ring of 8-byte descriptors, then a transmit ring of the same size, then the transmit buffers, 2 pad bytes, and finally the receive buffers.

Top module: `rxr_engine`

## Requirements
- R1: After reset, no memory request, frame ready, interrupt or missed pulse is active. The receive pointer is 0, so the first frame's first access is a read of base+26.
- R2: The status byte of entry i is read at base + 24 + 8*i + 2, at successive entries modulo 16. An entry is taken only if that byte is exactly 0x80; any other value, including 0x81, causes the scan to move on.
- R3: Frame byte k goes to base + 24986 + 1544*i + k, in arrival order, one write per byte. Frame ready stays low while the scan runs and while a byte write is outstanding.
- R4: After the last stored byte, the stored count is written big-endian. The high byte goes to base + 24 + 8*i + 6 and the low byte to offset 7.
- R5: The last access for a stored frame writes 0x03 to the entry's status byte. The receive interrupt goes high for exactly one cycle, on the cycle after that write is acknowledged.
- R6: After a frame is stored, the next scan starts at the entry after the one used, wrapping from 15 to 0.
- R7: If none of the 16 status bytes is 0x80, the frame is consumed with no writes and the pointer is left unchanged. The missed pulse is high for one cycle, with no request and no interrupt on that cycle.
- R8: A frame whose first byte is presented while stop is high is consumed with no memory access, no missed pulse and no interrupt.
- R9: Bytes beyond 1544 are consumed and discarded, and the stored count is then 1544.
- R10: A memory request keeps its address, direction and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stop_i | input | 1 | Engine stopped; frames starting now are dropped |
| ring_base_i | input | 32 | Base address of the shared memory region |
| frm_valid_i | input | 1 | Frame byte valid |
| frm_first_i | input | 1 | Byte is the first of a frame |
| frm_last_i | input | 1 | Byte is the last of a frame |
| frm_data_i | input | 8 | Frame byte |
| frm_ready_o | output | 1 | Engine accepts the presented byte at this edge |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_ack_i | input | 1 | Access done; read data valid |
| mem_rdata_i | input | 8 | Read data |
| rx_int_o | output | 1 | One-cycle receive interrupt request |
| miss_o | output | 1 | One-cycle missed-frame pulse |

## Verification
The hardest cases to reach are a scan that wraps past entry 15 and a scan that runs all 16 entries without success. Both depend on the pointer position that earlier frames left behind. The stimulus therefore runs a chain of frames against a memory model whose status bytes the bench sets between frames. Host-owned entries, an entry reading 0x81 and free entries placed behind the pointer steer the scan across the wrap and into an exhaustive miss. The memory model also stalls its acknowledges by a varying number of cycles, so that requests are held.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCAN,
      ST_COPY,
      ST_LEN_HI,
      ST_LEN_LO,
      ST_STAT,
      ST_DROP
   } rxr_state_e;

   localparam logic [7:0] DESC_FREE = 8'h80;
   localparam logic [7:0] DESC_DONE = 8'h03;
   localparam int unsigned DESC_BYTES = 8;
   localparam int unsigned STAT_OFS = 2;
   localparam int unsigned LEN_OFS = 6;
endpackage

// File: rtl/rxr_addr_map.sv
`timescale 1ns/1ps
module rxr_addr_map #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned HDR_BYTES  = 24,
   parameter int unsigned DESC_BYTES = 8,
   parameter int unsigned BUF_BYTES  = 1544,
   parameter int unsigned BUF_OFS    = 24986
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [ADDR_W-1:0] desc_o,
   output logic [ADDR_W-1:0] buf_o
);
   localparam int unsigned DESC_SH = $clog2(DESC_BYTES);

   assign desc_o = base_i + ADDR_W'(HDR_BYTES) + (ADDR_W'(idx_i) << DESC_SH);

   generate
      if ((BUF_BYTES & (BUF_BYTES - 1)) == 0) begin : g_buf_shift
         localparam int unsigned BUF_SH = $clog2(BUF_BYTES);
         assign buf_o = base_i + ADDR_W'(BUF_OFS) + (ADDR_W'(idx_i) << BUF_SH);
      end else begin : g_buf_mul
         assign buf_o = base_i + ADDR_W'(BUF_OFS) + ADDR_W'(idx_i) * ADDR_W'(BUF_BYTES);
      end
   endgenerate
endmodule

// File: rtl/rxr_len_ctr.sv
`timescale 1ns/1ps
module rxr_len_ctr #(
   parameter int unsigned LEN_W = 11,
   parameter int unsigned LIMIT = 1544
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [LEN_W-1:0] cnt_o,
   output logic             full_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_o <= '0;
      else if (clr_i)
         cnt_o <= '0;
      else if (inc_i && !full_o)
         cnt_o <= cnt_o + LEN_W'(1);
   end

   assign full_o = (cnt_o == LEN_W'(LIMIT));
endmodule

// File: rtl/rxr_engine.sv
`timescale 1ns/1ps
module rxr_engine #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned RING_LOG2 = 4,
   parameter int unsigned BUF_BYTES = 1544,
   parameter int unsigned HDR_BYTES = 24,
   parameter int unsigned PAD_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_i,
   input  logic [ADDR_W-1:0] ring_base_i,
   input  logic              frm_valid_i,
   input  logic              frm_first_i,
   input  logic              frm_last_i,
   input  logic [7:0]        frm_data_i,
   output logic              frm_ready_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [7:0]        mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [7:0]        mem_rdata_i,
   output logic              rx_int_o,
   output logic              miss_o
);
   import rxr_pkg::*;

   localparam int unsigned ENTRIES = 1 << RING_LOG2;
   localparam int unsigned IDX_W   = RING_LOG2;
   localparam int unsigned LEN_W   = $clog2(BUF_BYTES + 1);
   localparam int unsigned BUF_OFS = HDR_BYTES + 2 * ENTRIES * DESC_BYTES
                                     + ENTRIES * BUF_BYTES + PAD_BYTES;

   generate
      if (BUF_BYTES < 1 || BUF_BYTES > 65535) begin : g_bad_buf
         $error("rxr_engine: buffer size must fit the 16-bit length field");
      end
      if (RING_LOG2 < 1 || RING_LOG2 > 8) begin : g_bad_ring
         $error("rxr_engine: ring size out of range");
      end
      if (ADDR_W < 16) begin : g_bad_addr
         $error("rxr_engine: address too narrow");
      end
   endgenerate

   rxr_state_e        state_q;
   logic [IDX_W-1:0]  ptr_q;
   logic [IDX_W-1:0]  cur_q;
   logic [IDX_W-1:0]  tries_q;
   logic              pend_q;
   logic              last_q;
   logic [7:0]        wbyte_q;
   logic              rint_q;
   logic              miss_q;

   logic [ADDR_W-1:0] desc_a;
   logic [ADDR_W-1:0] buf_a;
   logic [LEN_W-1:0]  cnt;
   logic              full;
   logic              cnt_clr;
   logic              cnt_inc;
   logic [15:0]       len16;

   rxr_addr_map #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HDR_BYTES(HDR_BYTES),
      .DESC_BYTES(DESC_BYTES), .BUF_BYTES(BUF_BYTES), .BUF_OFS(BUF_OFS)
   ) u_map (
      .base_i(ring_base_i), .idx_i(cur_q), .desc_o(desc_a), .buf_o(buf_a)
   );

   rxr_len_ctr #(.LEN_W(LEN_W), .LIMIT(BUF_BYTES)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
      .cnt_o(cnt), .full_o(full)
   );

   assign len16   = 16'(cnt);
   assign cnt_clr = (state_q == ST_SCAN) && mem_ack_i && (mem_rdata_i == DESC_FREE);
   assign cnt_inc = (state_q == ST_COPY) && pend_q && mem_ack_i;

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = desc_a + ADDR_W'(STAT_OFS);
      mem_wdata_o = 8'h00;
      frm_ready_o = 1'b0;
      unique case (state_q)
         ST_SCAN: mem_req_o = 1'b1;
         ST_COPY: begin
            mem_req_o   = pend_q;
            mem_we_o    = 1'b1;
            mem_addr_o  = buf_a + ADDR_W'(cnt);
            mem_wdata_o = wbyte_q;
            frm_ready_o = !pend_q;
         end
         ST_LEN_HI: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = desc_a + ADDR_W'(LEN_OFS);
            mem_wdata_o = len16[15:8];
         end
         ST_LEN_LO: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = desc_a + ADDR_W'(LEN_OFS + 1);
            mem_wdata_o = len16[7:0];
         end
         ST_STAT: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_wdata_o = DESC_DONE;
         end
         ST_DROP: frm_ready_o = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ptr_q   <= '0;
         cur_q   <= '0;
         tries_q <= '0;
         pend_q  <= 1'b0;
         last_q  <= 1'b0;
         wbyte_q <= 8'h00;
         rint_q  <= 1'b0;
         miss_q  <= 1'b0;
      end else begin
         rint_q <= 1'b0;
         miss_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (frm_valid_i && frm_first_i) begin
                  cur_q   <= ptr_q;
                  tries_q <= '0;
                  state_q <= stop_i ? ST_DROP : ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (mem_ack_i) begin
                  if (mem_rdata_i == DESC_FREE) begin
                     pend_q  <= 1'b0;
                     state_q <= ST_COPY;
                  end else if (tries_q == IDX_W'(ENTRIES - 1)) begin
                     miss_q  <= 1'b1;
                     state_q <= ST_DROP;
                  end else begin
                     cur_q   <= cur_q + IDX_W'(1);
                     tries_q <= tries_q + IDX_W'(1);
                  end
               end
            end
            ST_COPY: begin
               if (pend_q) begin
                  if (mem_ack_i) begin
                     pend_q <= 1'b0;
                     if (last_q) state_q <= ST_LEN_HI;
                  end
               end else if (frm_valid_i) begin
                  last_q <= frm_last_i;
                  if (!full) begin
                     pend_q  <= 1'b1;
                     wbyte_q <= frm_data_i;
                  end else if (frm_last_i) begin
                     state_q <= ST_LEN_HI;
                  end
               end
            end
            ST_LEN_HI: if (mem_ack_i) state_q <= ST_LEN_LO;
            ST_LEN_LO: if (mem_ack_i) state_q <= ST_STAT;
            ST_STAT: begin
               if (mem_ack_i) begin
                  ptr_q   <= cur_q + IDX_W'(1);
                  rint_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_DROP: if (frm_valid_i && frm_last_i) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rx_int_o = rint_q;
   assign miss_o   = miss_q;
endmodule

// File: rtl/rxr_engine_chk.sv
`timescale 1ns/1ps
module rxr_engine_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_ready_o,
   input logic              mem_req_o,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [7:0]        mem_wdata_o,
   input logic              mem_ack_i,
   input logic              rx_int_o,
   input logic              miss_o
);
   // R10: a pending request holds its fields
   p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                  && $stable(mem_we_o) && $stable(mem_wdata_o));

   // R3: no byte is taken while a memory access is open
   p_ready_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frm_ready_o |-> !mem_req_o);

   // R5: interrupt follows an acknowledged completion write
   p_int_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_int_o |-> $past(mem_req_o && mem_ack_i && mem_we_o && mem_wdata_o == 8'h03));

   // R5: interrupt is a single-cycle pulse
   p_int_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_int_o |=> !rx_int_o);

   // R7: missed pulse is alone and single-cycle
   p_miss_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o |-> !mem_req_o && !rx_int_o);

   p_miss_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o |=> !miss_o);
endmodule

bind rxr_engine rxr_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frm_ready_o(frm_ready_o),
   .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
   .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
   .rx_int_o(rx_int_o), .miss_o(miss_o)
);

// File: tb/rxr_engine_tb_top.sv
`timescale 1ns/1ps
module rxr_engine_tb_top;
   localparam logic [31:0] BASE = 32'h0000_1000;
   localparam int RING  = 16;
   localparam int BUFSZ = 1544;
   localparam int BUFOF = 24986;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stop_i = 1'b0;
   logic        frm_valid_i = 1'b0, frm_first_i = 1'b0, frm_last_i = 1'b0;
   logic [7:0]  frm_data_i = 8'h00;
   logic        frm_ready_o, mem_req_o, mem_we_o, rx_int_o, miss_o;
   logic [31:0] mem_addr_o;
   logic [7:0]  mem_wdata_o;
   logic        mem_ack_i = 1'b0;
   logic [7:0]  mem_rdata_i = 8'h00;

   always #5 clk = ~clk;

   rxr_engine dut_i (
      .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .ring_base_i(BASE),
      .frm_valid_i(frm_valid_i), .frm_first_i(frm_first_i),
      .frm_last_i(frm_last_i), .frm_data_i(frm_data_i),
      .frm_ready_o(frm_ready_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
      .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
      .rx_int_o(rx_int_o), .miss_o(miss_o)
   );

   typedef struct {
      logic        we;
      logic [31:0] addr;
      logic [7:0]  data;
      string       tag;
   } acc_t;

   acc_t        exp_q[$];
   logic [7:0]  mem [int unsigned];
   int          total = 0, bad = 0;
   int          rint_cnt = 0, miss_cnt = 0, exp_rint = 0, exp_miss = 0;
   int          ptr_m = 0;
   logic [31:0] first_addr = '0;
   bit          seen_first = 0;
   bit          finished = 0;

   task automatic chk(bit ok, string tag, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] desc_a(int i);
      return BASE + 32'd24 + 32'(8 * i);
   endfunction

   function automatic logic [7:0] rd_mem(logic [31:0] a);
      return mem.exists(a) ? mem[a] : 8'h00;
   endfunction

   // memory model and monitor
   bit          hold_v = 0;
   logic [31:0] hold_a;
   logic [7:0]  hold_d;
   logic        hold_w;
   int          wait_n = 0, stall_seq = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack_i <= 1'b0;
         hold_v = 0;
      end else begin
         if (rx_int_o) rint_cnt++;
         if (miss_o) miss_cnt++;
         if (mem_req_o && !mem_ack_i) begin
            if (hold_v)
               chk(mem_addr_o == hold_a && mem_we_o == hold_w && mem_wdata_o == hold_d,
                   "R10 held request", mem_addr_o, hold_a);
            if (wait_n != 0) begin
               wait_n--;
               hold_v = 1; hold_a = mem_addr_o; hold_d = mem_wdata_o; hold_w = mem_we_o;
            end else begin
               hold_v = 0;
               stall_seq++;
               wait_n = stall_seq % 3;
               mem_ack_i <= 1'b1;
               mem_rdata_i <= rd_mem(mem_addr_o);
               if (!seen_first) begin seen_first = 1; first_addr = mem_addr_o; end
               if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
               if (exp_q.size() == 0) begin
                  chk(0, "R7 R8 unexpected access", mem_addr_o, 0);
               end else begin
                  acc_t e;
                  e = exp_q.pop_front();
                  chk(mem_we_o == e.we && mem_addr_o == e.addr &&
                      (!e.we || mem_wdata_o == e.data),
                      e.tag, {mem_we_o, mem_addr_o, mem_wdata_o},
                      {e.we, e.addr, e.we ? e.data : mem_wdata_o});
               end
            end
         end else begin
            mem_ack_i <= 1'b0;
            hold_v = 0;
         end
      end
   end

   function automatic logic [7:0] pat(int seed, int b);
      return 8'((seed + b * 7) & 255);
   endfunction

   task automatic push(logic we, logic [31:0] a, logic [7:0] d, string tag);
      acc_t e;
      e.we = we; e.addr = a; e.data = d; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // driver: builds expectations from the requirements, then streams
   task automatic run_frame(int len, int seed, bit stopped);
      int found = -1;
      if (!stopped) begin
         for (int k = 0; k < RING; k++) begin
            int e = (ptr_m + k) % RING;
            push(1'b0, desc_a(e) + 32'd2, 8'h00, (k == 0) ? "R6 scan start" : "R2 scan");
            if (rd_mem(desc_a(e) + 32'd2) == 8'h80) begin found = e; break; end
         end
         if (found < 0) exp_miss++;
         else begin
            int n = (len > BUFSZ) ? BUFSZ : len;
            for (int b = 0; b < n; b++)
               push(1'b1, BASE + 32'(BUFOF) + 32'(BUFSZ * found) + 32'(b), pat(seed, b),
                    (b == BUFSZ - 1) ? "R9 data" : "R3 data");
            push(1'b1, desc_a(found) + 32'd6, 8'(n >> 8), "R4 len hi");
            push(1'b1, desc_a(found) + 32'd7, 8'(n & 255), "R4 len lo");
            push(1'b1, desc_a(found) + 32'd2, 8'h03, "R5 done status");
            exp_rint++;
            ptr_m = (found + 1) % RING;
         end
      end
      for (int b = 0; b < len; b++) begin
         @(negedge clk);
         frm_valid_i = 1'b1;
         frm_first_i = (b == 0);
         frm_last_i  = (b == len - 1);
         frm_data_i  = pat(seed, b);
         #1;
         while (!frm_ready_o) begin @(negedge clk); #1; end
         @(posedge clk);
      end
      @(negedge clk);
      frm_valid_i = 1'b0; frm_first_i = 1'b0; frm_last_i = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(rint_cnt == exp_rint, "R5 interrupt count", rint_cnt, exp_rint);
      chk(miss_cnt == exp_miss, "R7 missed count", miss_cnt, exp_miss);
      chk(exp_q.size() == 0, "R3 all accesses seen", exp_q.size(), 0);
   endtask

   task automatic set_st(int i, logic [7:0] v);
      mem[desc_a(i) + 32'd2] = v;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < RING; i++) set_st(i, 8'h00);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      chk(!mem_req_o && !frm_ready_o && !rx_int_o && !miss_o, "R1 reset outputs",
          {mem_req_o, frm_ready_o, rx_int_o, miss_o}, 0);

      set_st(0, 8'h80);
      run_frame(5, 16, 0);
      chk(first_addr == BASE + 32'd26, "R1 first read address", first_addr, BASE + 32'd26);

      // R2: host-owned and 0x81 entries are skipped
      set_st(2, 8'h81); set_st(3, 8'h80);
      run_frame(3, 40, 0);

      // R7: nothing free anywhere
      run_frame(4, 70, 0);
      chk(ptr_m == 4, "R7 pointer model", ptr_m, 4);

      // R6 R4: wrap past 15, length above 255
      set_st(2, 8'h80);
      run_frame(300, 3, 0);

      // R8: stopped frame touches nothing
      set_st(3, 8'h80);
      stop_i = 1'b1;
      run_frame(4, 90, 1);
      stop_i = 1'b0;

      // R9: oversize frame truncated
      run_frame(BUFSZ + 6, 11, 0);

      // R6: pointer wraps from 15 to 0
      set_st(15, 8'h80);
      run_frame(2, 5, 0);
      set_st(0, 8'h80); set_st(1, 8'h80);
      run_frame(6, 21, 0);

      finish_run();
   end
endmodule